// File: doc/BRIEF.md
# Highway and Farm-Road Signal Controller

This block sequences the lamps of a crossing between a busy highway and a lightly used farm road. The highway shows green by default. A vehicle detector on the farm road asks for service. The controller answers with a yellow warning on the highway, then green for the farm road, then a yellow warning on the farm road, and then a return to highway green. An internal interval counter measures every phase. It restarts whenever the controller raises its one-cycle start pulse. It reports a short elapsed interval, which times the yellow phases, and a long elapsed interval, which times the green phases. Both intervals are parameters given in clock cycles.

The farm road keeps green only while a vehicle is detected, and never past the long interval. The highway always keeps green for at least the long interval, even when farm-road vehicles are already waiting. The lamp outputs depend on the phase register only. The start pulse is formed from the phase, the interval flags and the detector input in the same cycle.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the controller into highway green. The highway lamp reads 3'b001 and the farm lamp reads 3'b100. The interval count restarts from zero. Lamp encoding, bit 0 = green, bit 1 = yellow, bit 2 = red.
- R2: Highway green is left only in a cycle where `car_waiting` is high and at least LONG_CYCLES cycles have passed since the phase began. In that cycle `tmr_start` is high, and on the next edge the highway lamp turns yellow.
- R3: Highway yellow lasts exactly SHORT_CYCLES+1 cycles. `tmr_start` is high in its last cycle, and farm green follows.
- R4: During farm green, a low `car_waiting` raises `tmr_start` in the same cycle, and the farm lamp turns yellow on the next edge.
- R5: During farm green, once LONG_CYCLES cycles have passed since the phase began, `tmr_start` is high even while `car_waiting` stays high, and farm yellow follows.
- R6: Farm yellow lasts exactly SHORT_CYCLES+1 cycles. `tmr_start` is high in its last cycle, and highway green follows.
- R7: Both interval flags are measured from the most recent `tmr_start`, and both are low in the cycle after it. Each highway green therefore lasts at least LONG_CYCLES+1 cycles.
- R8: Each road shows exactly one lamp in every cycle, and at least one road shows red.
- R9: The lamps change only on the edge that follows a cycle with `tmr_start` high, and they always change on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car_waiting | input | 1 | Farm-road vehicle detector |
| hwy_lamp | output | 3 | Highway lamps {red, yellow, green}, one-hot |
| farm_lamp | output | 3 | Farm-road lamps {red, yellow, green}, one-hot |
| tmr_start | output | 1 | Phase-change and interval-restart pulse |

## Verification
`tmr_start` is due in the same cycle as the detector value and interval count that cause it. The lamps are due one edge later, and the interval flags rise SHORT_CYCLES or LONG_CYCLES edges after the edge that restarts the count. The bench applies each new detector value at the falling edge and samples one time unit later. It compares the start pulse against its model for the current cycle, and only then advances the model across the coming rising edge. The lamps are checked against the model state after that edge. Phase lengths are measured from the observed lamp runs, so an off-by-one in the counter shows up as a wrong run length.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  localparam int LAMP_W = 3;
  localparam int ROADS  = 2;
  typedef logic [LAMP_W-1:0] lamp_t;

  localparam lamp_t LAMP_GREEN  = 3'b001;
  localparam lamp_t LAMP_YELLOW = 3'b010;
  localparam lamp_t LAMP_RED    = 3'b100;

  // Bits needed to count from zero up to lim inclusive.
  function automatic int count_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Phase order is fixed; the cycle wraps from the farm warning back to highway go.
  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_HWY_GO:   return PH_HWY_WARN;
      PH_HWY_WARN: return PH_FARM_GO;
      PH_FARM_GO:  return PH_FARM_WARN;
      default:     return PH_HWY_GO;
    endcase
  endfunction

  // Exit condition of each phase, evaluated in the current cycle.
  function automatic logic leave_phase(input phase_t p, input logic car,
                                       input logic short_done, input logic long_done);
    case (p)
      PH_HWY_GO:   return car & long_done;
      PH_HWY_WARN: return short_done;
      PH_FARM_GO:  return ~car | long_done;
      default:     return short_done;
    endcase
  endfunction

  // Lamp for road index 0 (highway) or 1 (farm road) in a given phase.
  function automatic lamp_t lamp_of(input phase_t p, input int road);
    lamp_t l;
    l = LAMP_RED;
    if (road == 0) begin
      if (p == PH_HWY_GO)   l = LAMP_GREEN;
      if (p == PH_HWY_WARN) l = LAMP_YELLOW;
    end else begin
      if (p == PH_FARM_GO)   l = LAMP_GREEN;
      if (p == PH_FARM_WARN) l = LAMP_YELLOW;
    end
    return l;
  endfunction

endpackage

// File: rtl/xroad_interval_timer.sv
module xroad_interval_timer #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  import xroad_pkg::*;

  localparam int CNT_W = count_width(LONG_CYCLES);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYCLES);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // Count saturates at the long limit so it never wraps back below a threshold.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v >= LONG_LIM) ? LONG_LIM : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= sat_inc(cnt_q);
  end

  assign short_done = (cnt_q >= SHORT_LIM);
  assign long_done  = (cnt_q >= LONG_LIM);

endmodule

// File: rtl/xroad_phase_fsm.sv
module xroad_phase_fsm (
  input  logic              clk,
  input  logic              rst,
  input  logic              car,
  input  logic              short_done,
  input  logic              long_done,
  output xroad_pkg::phase_t phase,
  output logic              advance
);
  import xroad_pkg::*;

  phase_t phase_q;

  assign advance = leave_phase(phase_q, car, short_done, long_done);

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= PH_HWY_GO;
    else if (advance) phase_q <= next_phase(phase_q);
  end

  assign phase = phase_q;

endmodule

// File: rtl/xroad_lamp_decode.sv
module xroad_lamp_decode (
  input  xroad_pkg::phase_t phase,
  output logic [xroad_pkg::ROADS*xroad_pkg::LAMP_W-1:0] lamps
);
  import xroad_pkg::*;

  for (genvar r = 0; r < ROADS; r++) begin : g_road
    assign lamps[r*LAMP_W +: LAMP_W] = lamp_of(phase, r);
  end

endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_waiting,
  output logic [2:0] hwy_lamp,
  output logic [2:0] farm_lamp,
  output logic       tmr_start
);
  import xroad_pkg::*;

  // Internal events, named so the checker can observe them.
  logic   short_done;
  logic   long_done;
  phase_t phase_now;
  logic [ROADS*LAMP_W-1:0] lamps;

  xroad_interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (tmr_start),
    .short_done(short_done),
    .long_done (long_done)
  );

  xroad_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .car       (car_waiting),
    .short_done(short_done),
    .long_done (long_done),
    .phase     (phase_now),
    .advance   (tmr_start)
  );

  xroad_lamp_decode u_lamps (
    .phase(phase_now),
    .lamps(lamps)
  );

  assign hwy_lamp  = lamps[0 +: LAMP_W];
  assign farm_lamp = lamps[LAMP_W +: LAMP_W];

endmodule

// File: rtl/xroad_signal_checker.sv
module xroad_signal_checker (
  input logic       clk,
  input logic       rst,
  input logic       car,
  input logic [2:0] hwy,
  input logic [2:0] farm,
  input logic       st,
  input logic       ts,
  input logic       tl
);
  localparam logic [2:0] GRN = 3'b001;
  localparam logic [2:0] YEL = 3'b010;
  localparam logic [2:0] RED = 3'b100;

  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (hwy == GRN && farm == RED && !ts && !tl));

  assert_hwy_exit_cond_R2: assert property (@(posedge clk) disable iff (rst)
    (hwy == GRN && st) |-> (car && tl));

  assert_hwy_warn_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (hwy == YEL) |-> (st == ts));

  assert_farm_car_gone_R4: assert property (@(posedge clk) disable iff (rst)
    (farm == GRN && !car) |-> st);

  assert_farm_timeout_R5: assert property (@(posedge clk) disable iff (rst)
    (farm == GRN && tl) |-> st);

  assert_farm_warn_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (farm == YEL) |-> (st == ts));

  assert_timer_restart_R7: assert property (@(posedge clk) disable iff (rst)
    st |=> (!ts && !tl));

  assert_one_lamp_each_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(hwy) == 1 && $countones(farm) == 1 && (hwy == RED || farm == RED)));

  assert_hold_without_start_R9: assert property (@(posedge clk) disable iff (rst)
    !st |=> ($stable(hwy) && $stable(farm)));

  assert_move_on_start_R9: assert property (@(posedge clk) disable iff (rst)
    st |=> !$stable({hwy, farm}));

endmodule

bind xroad_signal_ctrl xroad_signal_checker u_checker (
  .clk (clk),
  .rst (rst),
  .car (car_waiting),
  .hwy (hwy_lamp),
  .farm(farm_lamp),
  .st  (tmr_start),
  .ts  (short_done),
  .tl  (long_done)
);

// File: tb/xroad_signal_ctrl_bench.sv
module xroad_signal_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S = 3;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_waiting = 1'b0;
  logic [2:0] hwy_lamp, farm_lamp;
  logic tmr_start;

  xroad_signal_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) u_xroad_signal_ctrl (
    .clk(clk), .rst(rst), .car_waiting(car_waiting),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp), .tmr_start(tmr_start));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Model: phase 0 hwy go, 1 hwy warn, 2 farm go, 3 farm warn; age = cycles in phase.
  int m_ph = 0;
  int m_age = 0;

  // Observed lamp runs.
  logic [2:0] prev_h = 3'b001, prev_f = 3'b100;
  int run_h = 0, run_f = 0;
  bit runs_ok = 0;
  int farm_timeouts = 0, farm_dropouts = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int exp_lamp(input int ph, input int road);
    if (road == 0) return (ph == 0) ? 1 : (ph == 1) ? 2 : 4;
    return (ph == 2) ? 1 : (ph == 3) ? 2 : 4;
  endfunction

  function automatic bit exp_start(input int ph, input int age, input bit c);
    case (ph)
      0: return c && age >= L;
      1: return age >= S;
      2: return !c || age >= L;
      default: return age >= S;
    endcase
  endfunction

  function automatic string tag_of(input int ph);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R4/R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a falling edge: apply inputs, check, advance the model across the next rising edge.
  task automatic step(input bit c, input bit r);
    bit es;
    rst = r;
    car_waiting = c;
    #1;
    es = exp_start(m_ph, m_age, c);
    chk(hwy_lamp == 3'(exp_lamp(m_ph, 0)), {tag_of(m_ph), " hwy lamp"}, int'(hwy_lamp), exp_lamp(m_ph, 0));
    chk(farm_lamp == 3'(exp_lamp(m_ph, 1)), {tag_of(m_ph), " farm lamp"}, int'(farm_lamp), exp_lamp(m_ph, 1));
    chk(tmr_start == es, "R9 start pulse", int'(tmr_start), int'(es));
    chk($countones(hwy_lamp) == 1 && $countones(farm_lamp) == 1 &&
        (hwy_lamp == 3'b100 || farm_lamp == 3'b100), "R8 lamp exclusivity",
        int'({hwy_lamp, farm_lamp}), -1);
    // Phase lengths from observed lamp runs.
    if (hwy_lamp != prev_h) begin
      if (runs_ok && prev_h == 3'b001) chk(run_h >= L + 1, "R7 highway min green", run_h, L + 1);
      if (runs_ok && prev_h == 3'b010) chk(run_h == S + 1, "R3 highway yellow length", run_h, S + 1);
      run_h = 1;
    end else run_h++;
    if (farm_lamp != prev_f) begin
      if (runs_ok && prev_f == 3'b010) chk(run_f == S + 1, "R6 farm yellow length", run_f, S + 1);
      if (runs_ok && prev_f == 3'b001) runs_ok = runs_ok;
      run_f = 1;
    end else run_f++;
    prev_h = hwy_lamp;
    prev_f = farm_lamp;
    if (m_ph == 2 && es) begin
      if (c) farm_timeouts++;
      else   farm_dropouts++;
    end
    if (r) begin
      m_ph = 0; m_age = 0; runs_ok = 0;
    end else if (es) begin
      m_ph = (m_ph + 1) % 4; m_age = 0;
    end else m_age++;
    @(negedge clk);
    cycles++;
    if (!r && m_ph == 0 && m_age == 0) runs_ok = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(hwy_lamp == 3'b001, "R1 reset hwy lamp", int'(hwy_lamp), 1);
    chk(farm_lamp == 3'b100, "R1 reset farm lamp", int'(farm_lamp), 4);
    chk(tmr_start == 1'b0, "R1 reset start pulse", int'(tmr_start), 0);
    m_ph = 0; m_age = 0;
    prev_h = hwy_lamp; prev_f = farm_lamp; run_h = 1; run_f = 1;
    @(negedge clk);
    // R2: no vehicle, highway holds green well past the long interval.
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0);
    chk(hwy_lamp == 3'b001, "R2 hold green without car", int'(hwy_lamp), 1);
    // R5 and R7: vehicle held high across complete cycles.
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0);
    chk(farm_timeouts > 0, "R5 farm green ended by long interval", farm_timeouts, 1);
    // R4: vehicle present until farm green, then it leaves.
    for (int i = 0; i < 40; i++) step(m_ph != 2, 1'b0);
    chk(farm_dropouts > 0, "R4 farm green ended by departure", farm_dropouts, 1);
    // Mixed traffic.
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], 1'b0);
    end
    // R1: reset while the farm road has green.
    for (int i = 0; i < 60 && m_ph != 2; i++) step(1'b1, 1'b0);
    chk(m_ph == 2, "R1 reached farm green before reset", m_ph, 2);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk(hwy_lamp == 3'b001 && farm_lamp == 3'b100, "R1 mid-run reset lamps",
        int'({hwy_lamp, farm_lamp}), 12);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule